// File: doc/BRIEF.md
# Symbol-wide Galois-field pattern generator

This block produces a parallel pseudorandom test pattern for built-in self-test. Its state is a chain of `STAGES` registers, each holding one `SYM_W`-bit symbol of the field GF(2^SYM_W). On every enabled clock each symbol moves one place along the chain. The symbol leaving the last place is fed back: it is multiplied by a fixed field constant for each place and added (XOR) into that place. Every multiplication is by a constant, so the whole update is an XOR network. Because a whole symbol is fed back at once, successive patterns differ in more bit positions than those of a one-bit shift register of the same length.

The default build uses two-bit symbols and three places, giving a six-bit pattern. The field is GF(4), reduced by x²+x+1, and α stands for x. The feedback polynomial is x³ + x² + α²x + α. With `SYM_W = 1` the multipliers fall away to plain taps and the block is an ordinary Galois shift register. A seed can be loaded at any time. Reset puts in a fixed seed.

Top module: `glfsr_gen`

## Requirements
- R1: A synchronous reset sets `pattern` to `RESET_SEED` (default all ones) at the next clock edge. Reset takes priority over seed load and enable.
- R2: When `seed_load` is high at a clock edge, `pattern` equals `seed` after that edge, whatever the value of `enable`.
- R3: When `seed_load` and `enable` are both low at a clock edge, `pattern` keeps its value.
- R4: Stage k occupies `pattern[k*SYM_W +: SYM_W]`, and its field coefficient of α^0 is the lower bit. In the default build, with s = old pattern, one enabled step gives: next[0]=s[5], next[1]=s[4]^s[5], next[2]=s[0]^s[4]^s[5], next[3]=s[1]^s[4], next[4]=s[2]^s[4], next[5]=s[3]^s[5].
- R5: In the default build, starting from 0x3F, three enabled steps give 0x05, then 0x14, then 0x0E.
- R6: When the last stage holds zero, an enabled step is a pure shift by one symbol, with zero entering stage 0 (for example 0x0B becomes 0x2C).
- R7: A zero seed is accepted, and the pattern then stays zero on every enabled step.
- R8: From a nonzero seed the pattern never becomes zero, and it returns to the seed within 2^(SYM_W*STAGES)-1 enabled steps.
- R9: With one-bit symbols, six stages and taps 0b000011, the block is a standard shift register: from 0x3F it steps to 0x3D, then 0x39, then 0x31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the generator by one step |
| seed_load | input | 1 | Replace the state with `seed` |
| seed | input | SYM_W*STAGES | Seed value |
| pattern | output | SYM_W*STAGES | Current test pattern (the register state) |

## Verification
Every result (reset, load, hold and a step) appears exactly one rising edge after the control that causes it, because the pattern is the register state itself with no logic after it. The bench changes its inputs on a falling edge and reads `pattern` on the next falling edge, so each check sees the edge that its stimulus caused and no other. The long walk advances one step for each read and moves an independent reference model forward by one step each time. The shift register with one-bit symbols runs in its own instance, on the same timing.

// File: rtl/glfsr_pkg.sv
package glfsr_pkg;

   // widest symbol the constant multiplier supports
   localparam int unsigned GF_MAX_W = 16;

   typedef logic [GF_MAX_W-1:0] gf_word_t;

   // Product a*b in GF(2^w). poly_low holds the reduction polynomial without its x^w term.
   // When b is constant this unrolls to XOR gates only.
   function automatic gf_word_t gf_mul(gf_word_t a, gf_word_t b, gf_word_t poly_low,
                                       int unsigned w);
      gf_word_t acc;
      gf_word_t sh;
      gf_word_t mask;
      logic     carry;
      acc  = '0;
      sh   = a;
      mask = gf_word_t'((32'd1 << w) - 32'd1);
      for (int unsigned i = 0; i < GF_MAX_W; i++) begin
         if (i < w) begin
            if (b[i]) acc = acc ^ sh;
            carry = sh[w-1];
            sh    = (sh << 1) & mask;
            if (carry) sh = sh ^ poly_low;
         end
      end
      return acc & mask;
   endfunction

endpackage

// File: rtl/glfsr_cmul.sv
module glfsr_cmul
   import glfsr_pkg::*;
#(
   parameter int unsigned        SYM_W     = 2,
   parameter logic [SYM_W-1:0]   COEF      = '1,
   parameter logic [SYM_W-1:0]   FIELD_LOW = '1
) (
   input  logic [SYM_W-1:0] din,
   output logic [SYM_W-1:0] dout
);

   generate
      if (SYM_W == 1) begin : g_tap
         // binary field: the coefficient is a plain tap
         assign dout = COEF[0] ? din : 1'b0;
      end else begin : g_field
         always_comb begin
            dout = SYM_W'(gf_mul(gf_word_t'(din), gf_word_t'(COEF),
                                 gf_word_t'(FIELD_LOW), SYM_W));
         end
      end
   endgenerate

endmodule

// File: rtl/glfsr_stage.sv
module glfsr_stage #(
   parameter int unsigned        SYM_W     = 2,
   parameter logic [SYM_W-1:0]   COEF      = '1,
   parameter logic [SYM_W-1:0]   FIELD_LOW = '1,
   parameter logic [SYM_W-1:0]   RESET_SYM = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             seed_load,
   input  logic             enable,
   input  logic [SYM_W-1:0] seed_sym,
   input  logic [SYM_W-1:0] prev_sym,
   input  logic [SYM_W-1:0] fb_sym,
   output logic [SYM_W-1:0] q
);

   logic [SYM_W-1:0] fb_term;

   glfsr_cmul #(
      .SYM_W    (SYM_W),
      .COEF     (COEF),
      .FIELD_LOW(FIELD_LOW)
   ) i_cmul (
      .din (fb_sym),
      .dout(fb_term)
   );

   always_ff @(posedge clk) begin
      if (rst)            q <= RESET_SYM;
      else if (seed_load) q <= seed_sym;
      else if (enable)    q <= prev_sym ^ fb_term;
   end

   // R3: an idle cycle leaves the stage untouched
   assert_stage_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!seed_load && !enable) |=> $stable(q));

endmodule

// File: rtl/glfsr_gen.sv
module glfsr_gen
   import glfsr_pkg::*;
#(
   parameter int unsigned                 SYM_W      = 2,
   parameter int unsigned                 STAGES     = 3,
   parameter logic [SYM_W-1:0]            FIELD_LOW  = '1,
   parameter logic [SYM_W*STAGES-1:0]     COEFFS     = 6'b01_11_10,
   parameter logic [SYM_W*STAGES-1:0]     RESET_SEED = '1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      enable,
   input  logic                      seed_load,
   input  logic [SYM_W*STAGES-1:0]   seed,
   output logic [SYM_W*STAGES-1:0]   pattern
);

   localparam int unsigned PAT_W = SYM_W * STAGES;
   localparam int unsigned LAST  = STAGES - 1;

   // elaboration-time parameter checks
   generate
      if (SYM_W < 1 || SYM_W > GF_MAX_W) begin : g_bad_width
         $error("glfsr_gen: SYM_W out of range");
      end
      if (STAGES < 2) begin : g_bad_depth
         $error("glfsr_gen: STAGES must be at least 2");
      end
      if (COEFFS[SYM_W-1:0] == '0) begin : g_bad_const
         $error("glfsr_gen: constant coefficient must be nonzero");
      end
   endgenerate

   logic [SYM_W-1:0] sym_q  [STAGES];
   logic [SYM_W-1:0] fb_sym;

   assign fb_sym = sym_q[LAST];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         logic [SYM_W-1:0] prev_sym;
         if (k == 0) begin : g_head
            assign prev_sym = '0;
         end else begin : g_body
            assign prev_sym = sym_q[k-1];
         end

         glfsr_stage #(
            .SYM_W    (SYM_W),
            .COEF     (COEFFS[k*SYM_W +: SYM_W]),
            .FIELD_LOW(FIELD_LOW),
            .RESET_SYM(RESET_SEED[k*SYM_W +: SYM_W])
         ) i_stage (
            .clk      (clk),
            .rst      (rst),
            .seed_load(seed_load),
            .enable   (enable),
            .seed_sym (seed[k*SYM_W +: SYM_W]),
            .prev_sym (prev_sym),
            .fb_sym   (fb_sym),
            .q        (sym_q[k])
         );

         assign pattern[k*SYM_W +: SYM_W] = sym_q[k];
      end
   endgenerate

   // R2: loading wins over stepping
   assert_seed_load_R2: assert property (@(posedge clk) disable iff (rst)
      seed_load |=> (pattern == $past(seed)));

   // R6: zero feedback gives a pure one-symbol shift
   assert_zero_fb_shift_R6: assert property (@(posedge clk) disable iff (rst)
      (enable && !seed_load && (fb_sym == '0)) |=>
         (pattern == PAT_W'($past(pattern) << SYM_W)));

   // R7: the all-zero state is a fixed point
   assert_zero_lock_R7: assert property (@(posedge clk) disable iff (rst)
      ((pattern == '0) && !seed_load) |=> (pattern == '0));

   // R8: a nonzero state never steps to zero
   assert_no_zero_R8: assert property (@(posedge clk) disable iff (rst)
      ((pattern != '0) && !seed_load) |=> (pattern != '0));

endmodule

// File: tb/test_glfsr_gen.sv
module test_glfsr_gen;

   typedef struct packed {
      logic       ld;
      logic       en;
      logic [5:0] seed;
      logic [5:0] exp;
   } vec_t;

   // applied from the reset state 0x3F, one row per clock
   localparam vec_t VECS [11] = '{
      '{1'b0, 1'b1, 6'h00, 6'h05},   // R5 step 1
      '{1'b0, 1'b1, 6'h00, 6'h14},   // R5 step 2
      '{1'b0, 1'b1, 6'h00, 6'h0E},   // R5 step 3
      '{1'b0, 1'b0, 6'h15, 6'h0E},   // R3 hold
      '{1'b1, 1'b1, 6'h2A, 6'h2A},   // R2 load over enable
      '{1'b0, 1'b1, 6'h00, 6'h0F},   // R4 step from 0x2A
      '{1'b1, 1'b0, 6'h0B, 6'h0B},   // R2 load
      '{1'b0, 1'b1, 6'h00, 6'h2C},   // R6 pure shift
      '{1'b1, 1'b0, 6'h00, 6'h00},   // R7 zero seed
      '{1'b0, 1'b1, 6'h00, 6'h00},   // R7 locked
      '{1'b0, 1'b1, 6'h00, 6'h00}    // R7 locked
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       enable = 1'b0;
   logic       seed_load = 1'b0;
   logic [5:0] seed = '0;
   logic [5:0] pattern;
   logic       en_b = 1'b0;
   logic [5:0] pattern_b;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   glfsr_gen i_glfsr_gen (
      .clk      (clk),
      .rst      (rst),
      .enable   (enable),
      .seed_load(seed_load),
      .seed     (seed),
      .pattern  (pattern)
   );

   glfsr_gen #(
      .SYM_W    (1),
      .STAGES   (6),
      .FIELD_LOW(1'b1),
      .COEFFS   (6'b000011)
   ) i_glfsr_gen_bit (
      .clk      (clk),
      .rst      (rst),
      .enable   (en_b),
      .seed_load(1'b0),
      .seed     (6'h00),
      .pattern  (pattern_b)
   );

   function automatic logic [5:0] ref_step(logic [5:0] s);
      logic [5:0] n;
      n[0] = s[5];
      n[1] = s[4] ^ s[5];
      n[2] = s[0] ^ s[4] ^ s[5];
      n[3] = s[1] ^ s[4];
      n[4] = s[2] ^ s[4];
      n[5] = s[3] ^ s[5];
      return n;
   endfunction

   task automatic check(string req, logic [5:0] act, logic [5:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [5:0] model;
      bit         returned;
      @(negedge clk);
      @(negedge clk);
      check("R1 reset main", pattern, 6'h3F);
      check("R1 reset bit", pattern_b, 6'h3F);
      rst = 1'b0;

      // R9: one-bit build steps while main stays idle (R3)
      en_b = 1'b1;
      @(negedge clk);
      check("R9 step1", pattern_b, 6'h3D);
      check("R3 idle main", pattern, 6'h3F);
      @(negedge clk);
      check("R9 step2", pattern_b, 6'h39);
      @(negedge clk);
      check("R9 step3", pattern_b, 6'h31);
      en_b = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;

      // vector table
      for (int i = 0; i < 11; i++) begin
         seed_load = VECS[i].ld;
         enable    = VECS[i].en;
         seed      = VECS[i].seed;
         @(negedge clk);
         check($sformatf("R2-R7 table row %0d", i), pattern, VECS[i].exp);
      end

      // R1: reset beats load and enable
      seed_load = 1'b1;
      enable    = 1'b1;
      seed      = 6'h2A;
      rst       = 1'b1;
      @(negedge clk);
      check("R1 reset priority", pattern, 6'h3F);
      rst = 1'b0;

      // R4 / R8: full walk against the reference model
      seed = 6'h01;
      @(negedge clk);
      check("R2 load walk seed", pattern, 6'h01);
      seed_load = 1'b0;
      model     = 6'h01;
      returned  = 1'b0;
      for (int s = 0; s < 63; s++) begin
         @(negedge clk);
         model = ref_step(model);
         check("R4 walk", pattern, model);
         if (pattern == 6'h00) check("R8 nonzero", pattern, model);
         if (pattern == 6'h01) returned = 1'b1;
      end
      n_checks++;
      if (!returned) begin
         n_errors++;
         $display("FAIL R8 no return actual=%0d expected=%0d", returned, 1);
      end
      enable = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule